// File: doc/BRIEF.md
# Per-Bit Access-Policy Register Bank

This block is a small bank of memory-mapped control and status registers. Each register carries its own reset value and four per-bit policy masks: read-only, write-one-to-clear, reserved, and clear-on-read. Requests arrive on a single-cycle bus port. Each request has an address, a write strobe, a read strobe, write data and an access size in bytes. The block answers with registered read data and a one-cycle error pulse.

Every cycle the block finds the register being addressed and turns the access size into a byte-lane mask. It then computes that register's next contents. A write changes only the unprotected bits inside the enabled lanes, and it clears the write-one-to-clear bits that are written as one. A read returns the lane-masked value and clears the clear-on-read bits inside those lanes. An access to an address with no register is flagged and has no effect. A write that would change a reserved bit is also flagged.

All widths, the register count and the per-register masks are parameters. The masks are packed with register 0 in the lowest bits.

Top module: `polreg_bank`

## Requirements
- R1: While reset is held and after it is released, every register holds its own configured reset value, and `bus_rdata` and `bus_err` are 0 until the first access.
- R2: On a served write to a mapped register, each bit inside the enabled lanes that is not read-only, not write-one-to-clear and not reserved takes the written value. Read-only bits, reserved bits and all bits outside the enabled lanes keep their old value.
- R3: On a served write, each write-one-to-clear bit inside the enabled lanes that is written as 1 becomes 0. A write-one-to-clear bit written as 0 keeps its value.
- R4: The access size `bus_size` (0 to 7) enables byte lane b when `bus_size` > b. Size 0 enables no lane, and sizes of 4 and above enable all four lanes of a 32-bit register. Read data bits outside the enabled lanes are 0.
- R5: A read of a mapped register returns the stored value ANDed with the lane mask. The data appears on `bus_rdata` in the cycle after the read strobe. `bus_rdata` holds its value in every cycle that follows a cycle with no read strobe.
- R6: A read clears, in the stored register, each clear-on-read bit inside the enabled lanes. Clear-on-read bits outside those lanes keep their value. The value returned is the one held before the clear.
- R7: An address is mapped only when it is a multiple of the register width in bytes and lies below NUM_REGS times that width. A write to an unmapped address changes no register. A read from one returns 0. Either access raises `bus_err` in the next cycle.
- R8: A served write that would change a reserved bit inside the enabled lanes (written value differs from stored value) raises `bus_err` in the next cycle. The reserved bit still keeps its old value.
- R9: When read and write strobes are both high, the read is served and the write is ignored. No reserved-bit error is raised for the ignored write, and a read of a mapped register never raises `bus_err`.
- R10: `bus_err` is 0 in the cycle after any cycle that has no access, no unmapped access and no reserved-bit change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe (wins over the write strobe) |
| bus_size | input | SIZE_W | Access size in bytes |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle error pulse for the previous access |

## Verification
The merge is swept over every register, every access size from 0 to 7, and four data patterns. The all-ones and all-zeros patterns separate bits that take the written value from protected bits. The alternating patterns expose lane errors and wrong reserved-bit comparisons. A read-size sweep follows each refill of the registers. It shows whether clear-on-read bits clear only inside the enabled lanes and whether out-of-lane read data is zero. A sweep over every address from 0x00 to 0x3F separates aligned hits from misaligned and out-of-range misses. Simultaneous read and write strobes check that the write is ignored.

// File: rtl/polreg_pkg.sv
package polreg_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic rd, input logic wr);
      if (rd)      return ACC_READ;
      else if (wr) return ACC_WRITE;
      else         return ACC_IDLE;
   endfunction

endpackage

// File: rtl/polreg_lane_mask.sv
module polreg_lane_mask #(
   parameter int DATA_W = 32,
   parameter int SIZE_W = 3
) (
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] lanes
);
   localparam int BYTES = DATA_W / 8;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign lanes[b*8 +: 8] = {8{(int'(size) > b)}};
   end
endmodule

// File: rtl/polreg_decode.sv
module polreg_decode #(
   parameter int ADDR_W   = 8,
   parameter int NUM_REGS = 8,
   parameter int BYTES    = 4
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel,
   output logic                hit
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
      assign sel[i] = (addr == ADDR_W'(i * BYTES));
   end
   assign hit = |sel;
endmodule

// File: rtl/polreg_cell.sv
module polreg_cell #(
   parameter int                 DATA_W = 32,
   parameter logic [DATA_W-1:0]  RST_VAL = '0,
   parameter logic [DATA_W-1:0]  RO_M    = '0,
   parameter logic [DATA_W-1:0]  W1C_M   = '0,
   parameter logic [DATA_W-1:0]  RSVD_M  = '0,
   parameter logic [DATA_W-1:0]  COR_M   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] lanes,
   output logic [DATA_W-1:0] q,
   output logic              rsvd_touch
);
   localparam logic [DATA_W-1:0] FIXED_KEEP = RO_M | W1C_M | RSVD_M;

   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] wr_next;
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] d;

   always_comb begin
      keep    = FIXED_KEEP | ~lanes;
      merged  = (wdata & ~keep) | (q & keep);
      wr_next = merged & ~(wdata & W1C_M & lanes);
   end

   if (COR_M == '0) begin : g_no_cor
      assign rd_next = q;
   end else begin : g_cor
      assign rd_next = q & ~(COR_M & lanes);
   end

   if (RSVD_M == '0) begin : g_no_rsvd
      assign rsvd_touch = 1'b0;
   end else begin : g_rsvd
      assign rsvd_touch = |((q ^ wdata) & RSVD_M & lanes);
   end

   always_comb begin
      if (wr_en)      d = wr_next;
      else if (rd_en) d = rd_next;
      else            d = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/polreg_bank.sv
module polreg_bank
   import polreg_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int SIZE_W   = 3,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS =
      {32'h0000FFFF, 32'hDEADBEEF, 32'h03CCF0A5, 32'h12345678,
       32'h00000000, 32'h000000FF, 32'hA5A50000, 32'h00000000},
   parameter logic [NUM_REGS*DATA_W-1:0] RO_MASKS =
      {32'h00000000, 32'hFFFFFFFF, 32'h000000F0, 32'h00000000,
       32'h00000000, 32'h00000000, 32'hFFFF0000, 32'h00000000},
   parameter logic [NUM_REGS*DATA_W-1:0] W1C_MASKS =
      {32'h00000000, 32'h00000000, 32'h0000FF00, 32'h00000000,
       32'h00000000, 32'h000000FF, 32'h00000000, 32'h00000000},
   parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASKS =
      {32'h00000000, 32'h00000000, 32'h0F000000, 32'h00000000,
       32'hF0000000, 32'h00000000, 32'h00000000, 32'h00000000},
   parameter logic [NUM_REGS*DATA_W-1:0] COR_MASKS =
      {32'h00000000, 32'h00000000, 32'h00FF0000, 32'h0000FFFF,
       32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic [SIZE_W-1:0] bus_size,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);
   localparam int BYTES     = DATA_W / 8;
   localparam int SPAN      = NUM_REGS * BYTES;
   localparam int SIZE_MAX  = (1 << SIZE_W) - 1;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("polreg_bank: DATA_W must be a positive multiple of 8");
   end
   if ((BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("polreg_bank: register width in bytes must be a power of two");
   end
   if (NUM_REGS < 1) begin : g_bad_count
      $error("polreg_bank: NUM_REGS must be at least 1");
   end
   if (ADDR_SPAN < SPAN) begin : g_bad_addr
      $error("polreg_bank: ADDR_W too narrow for the register span");
   end
   if (SIZE_MAX < BYTES) begin : g_bad_size
      $error("polreg_bank: SIZE_W cannot express a full-width access");
   end

   acc_kind_e           kind;
   logic [NUM_REGS-1:0] sel;
   logic                hit;
   logic [DATA_W-1:0]   lanes;
   logic                do_rd;
   logic                do_wr;
   logic [DATA_W-1:0]   q_vec    [NUM_REGS];
   logic [NUM_REGS-1:0] rsvd_vec;
   logic [DATA_W-1:0]   rd_val;
   logic                rsvd_any;
   logic                err_next;

   assign kind  = classify(bus_rd, bus_wr);
   assign do_rd = (kind == ACC_READ)  && hit;
   assign do_wr = (kind == ACC_WRITE) && hit;

   polreg_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_REGS(NUM_REGS),
      .BYTES   (BYTES)
   ) u_decode (
      .addr(bus_addr),
      .sel (sel),
      .hit (hit)
   );

   polreg_lane_mask #(
      .DATA_W(DATA_W),
      .SIZE_W(SIZE_W)
   ) u_lanes (
      .size (bus_size),
      .lanes(lanes)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      polreg_cell #(
         .DATA_W (DATA_W),
         .RST_VAL(RESET_VALS[i*DATA_W +: DATA_W]),
         .RO_M   (RO_MASKS  [i*DATA_W +: DATA_W]),
         .W1C_M  (W1C_MASKS [i*DATA_W +: DATA_W]),
         .RSVD_M (RSVD_MASKS[i*DATA_W +: DATA_W]),
         .COR_M  (COR_MASKS [i*DATA_W +: DATA_W])
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (do_wr && sel[i]),
         .rd_en     (do_rd && sel[i]),
         .wdata     (bus_wdata),
         .lanes     (lanes),
         .q         (q_vec[i]),
         .rsvd_touch(rsvd_vec[i])
      );
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) rd_val = rd_val | q_vec[i];
      end
   end

   assign rsvd_any = |(sel & rsvd_vec);
   assign err_next = ((kind != ACC_IDLE) && !hit) || (do_wr && rsvd_any);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= err_next;
         if (kind == ACC_READ) bus_rdata <= do_rd ? (rd_val & lanes) : '0;
      end
   end
endmodule

// File: rtl/polreg_chk.sv
module polreg_chk #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int SIZE_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [SIZE_W-1:0] bus_size,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err
);
   localparam int BYTES = DATA_W / 8;

   logic              mapped;
   int                nbytes;
   logic [DATA_W-1:0] lane_bits;

   always_comb begin
      mapped = ((int'(bus_addr) % BYTES) == 0) && ((int'(bus_addr) / BYTES) < NUM_REGS);
      nbytes = (int'(bus_size) > BYTES) ? BYTES : int'(bus_size);
      if (nbytes >= BYTES) lane_bits = '1;
      else                 lane_bits = (DATA_W'(1) << (nbytes * 8)) - DATA_W'(1);
   end

   // R7
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !mapped) |=> (bus_rdata == '0 && bus_err));

   // R7
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rd && !mapped) |=> bus_err);

   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R4
   lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> ((bus_rdata & ~$past(lane_bits)) == '0));

   // R10
   idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && !bus_wr) |=> !bus_err);

   // R9
   mapped_rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && mapped) |=> !bus_err);
endmodule

bind polreg_bank polreg_chk #(
   .NUM_REGS(NUM_REGS),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SIZE_W  (SIZE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_size (bus_size),
   .bus_rdata(bus_rdata),
   .bus_err  (bus_err)
);

// File: tb/polreg_bank_tb.sv
`timescale 1ns/1ps
module polreg_bank_tb;
   localparam int NR = 8;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int SW = 3;

   localparam logic [NR*DW-1:0] P_RST =
      {32'h0000FFFF, 32'hDEADBEEF, 32'h03CCF0A5, 32'h12345678,
       32'h00000000, 32'h000000FF, 32'hA5A50000, 32'h00000000};
   localparam logic [NR*DW-1:0] P_RO =
      {32'h00000000, 32'hFFFFFFFF, 32'h000000F0, 32'h00000000,
       32'h00000000, 32'h00000000, 32'hFFFF0000, 32'h00000000};
   localparam logic [NR*DW-1:0] P_W1C =
      {32'h00000000, 32'h00000000, 32'h0000FF00, 32'h00000000,
       32'h00000000, 32'h000000FF, 32'h00000000, 32'h00000000};
   localparam logic [NR*DW-1:0] P_RSVD =
      {32'h00000000, 32'h00000000, 32'h0F000000, 32'h00000000,
       32'hF0000000, 32'h00000000, 32'h00000000, 32'h00000000};
   localparam logic [NR*DW-1:0] P_COR =
      {32'h00000000, 32'h00000000, 32'h00FF0000, 32'h0000FFFF,
       32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [SW-1:0] bus_size = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_err;

   always #2 clk = ~clk;

   polreg_bank #(
      .NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .SIZE_W(SW),
      .RESET_VALS(P_RST), .RO_MASKS(P_RO), .W1C_MASKS(P_W1C),
      .RSVD_MASKS(P_RSVD), .COR_MASKS(P_COR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_size(bus_size),
      .bus_rdata(bus_rdata), .bus_err(bus_err)
   );

   logic [DW-1:0] model [NR];
   int checks = 0;
   int failures = 0;

   function automatic logic [DW-1:0] fld(input logic [NR*DW-1:0] v, input int r);
      return v[r*DW +: DW];
   endfunction

   function automatic logic [DW-1:0] lanes_of(input int sz);
      int n;
      n = (sz > 4) ? 4 : sz;
      if (n == 4) return '1;
      return (DW'(1) << (n * 8)) - DW'(1);
   endfunction

   function automatic string tag_for(input int r);
      case (r)
         2:       return "R3";
         3:       return "R8";
         4:       return "R6";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
      end
   endtask

   task automatic expect_op(input int a, input logic w, input logic r,
                            input logic [DW-1:0] d, input int sz,
                            output logic [DW-1:0] er, output logic ee);
      bit mapped;
      int idx;
      logic [DW-1:0] ln, keep, old;
      mapped = (a % 4 == 0) && (a / 4 < NR);
      idx = a / 4;
      ln = lanes_of(sz);
      er = '0;
      ee = 1'b0;
      if (r) begin
         if (mapped) begin
            er = model[idx] & ln;
            model[idx] = model[idx] & ~(fld(P_COR, idx) & ln);
         end else begin
            ee = 1'b1;
         end
      end else if (w) begin
         if (mapped) begin
            old = model[idx];
            ee = |((old ^ d) & fld(P_RSVD, idx) & ln);
            keep = fld(P_RO, idx) | fld(P_W1C, idx) | fld(P_RSVD, idx) | ~ln;
            model[idx] = ((d & ~keep) | (old & keep)) & ~(d & fld(P_W1C, idx) & ln);
         end else begin
            ee = 1'b1;
         end
      end
   endtask

   task automatic run(input string tag, input int a, input logic w, input logic r,
                      input logic [DW-1:0] d, input int sz);
      logic [DW-1:0] er, prev;
      logic ee;
      prev = bus_rdata;
      expect_op(a, w, r, d, sz, er, ee);
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_wr    = w;
      bus_rd    = r;
      bus_wdata = d;
      bus_size  = SW'(sz);
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      if (r) chk(tag, "rdata", bus_rdata, er);
      else   chk(tag, "rdata hold", bus_rdata, prev);
      chk(tag, "err", DW'(bus_err), DW'(ee));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] pats [4];
      pats[0] = 32'hFFFFFFFF;
      pats[1] = 32'h00000000;
      pats[2] = 32'hA5A5A5A5;
      pats[3] = 32'h5A5A5A5A;
      for (int r = 0; r < NR; r++) model[r] = fld(P_RST, r);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: outputs quiet after reset
      chk("R1", "rdata after reset", bus_rdata, '0);
      chk("R1", "err after reset", DW'(bus_err), '0);
      // R1: reset values
      for (int r = 0; r < NR; r++) run("R1", r * 4, 1'b0, 1'b1, '0, 4);

      // R2 R3 R8: write sweep over registers, sizes, patterns
      for (int r = 0; r < NR; r++) begin
         for (int sz = 0; sz < 8; sz++) begin
            foreach (pats[p]) begin
               run(tag_for(r), r * 4, 1'b1, 1'b0, pats[p], sz);
               run(tag_for(r), r * 4, 1'b0, 1'b1, '0, 4);
            end
         end
      end

      // R4 R6: read-size sweep after refilling each register
      for (int r = 0; r < NR; r++) begin
         for (int sz = 0; sz < 8; sz++) begin
            run("R2", r * 4, 1'b1, 1'b0, 32'hFFFFFFFF, 4);
            run((r == 4 || r == 5) ? "R6" : "R4", r * 4, 1'b0, 1'b1, '0, sz);
            run((r == 4 || r == 5) ? "R6" : "R4", r * 4, 1'b0, 1'b1, '0, 4);
         end
      end

      // R7 R5: address sweep, write then read at every byte address
      for (int a = 0; a < 64; a++) begin
         run((a % 4 == 0 && a < 32) ? "R2" : "R7", a, 1'b1, 1'b0, 32'h3C3C3C3C ^ a, 4);
         run((a % 4 == 0 && a < 32) ? "R5" : "R7", a, 1'b0, 1'b1, '0, 4);
      end
      for (int r = 0; r < NR; r++) run("R7", r * 4, 1'b0, 1'b1, '0, 4);

      // R9: both strobes, read wins, write ignored
      run("R9", 0, 1'b1, 1'b1, 32'h11112222, 4);
      run("R9", 0, 1'b0, 1'b1, '0, 4);
      run("R9", 12, 1'b1, 1'b1, 32'hFFFFFFFF, 4);
      run("R9", 12, 1'b0, 1'b1, '0, 4);

      // R10 R5: idle cycles keep err low and rdata held
      run("R10", 0, 1'b0, 1'b0, '0, 0);
      run("R5", 4, 1'b0, 1'b0, 32'hFFFFFFFF, 4);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule